// File: doc/BRIEF.md
# Picture Tube Start-Up Sequencer

This block steps the picture tube control loop through its start-up. From reset, and after every power-on reset event, it sits in a warm-up phase. In that phase the RGB outputs are blanked for the whole line scan, and a white monitor pulse is enabled during each vertical blanking window so that cathode current can be measured. A warm-up comparator result is taken only while blanking is active. Once it has been seen high in a blanking window, the next field boundary enables the cut-off and white-level control loops and stops the monitor pulse.

In the second phase the loops run but line-scan blanking stays on. It is released only after the loop-stable indication has held for a programmable number of whole consecutive fields. After that the sequencer stays in normal operation until the next power-on reset event.

A field boundary is the end of the blanking window by default. A parameter can move it to the start of the window.

Top module: `tube_startup_seq`

## Requirements
- R1: After `rst_n` is released, `scan_blank` is 1, `loop_en` is 0 and `monitor_en` is 0 while `vblank` is 0.
- R2: In the warm-up phase `monitor_en` follows `vblank` in the same cycle. In any other phase `monitor_en` is 0.
- R3: A high `warm_ok` while `vblank` is 0 is ignored: the sequencer stays in warm-up (`loop_en` stays 0).
- R4: If `warm_ok` is high in at least one blanking cycle, the phase changes at the next field boundary. That boundary is the first clock edge with `vblank` low after it was high. At that edge `loop_en` becomes 1 and the monitor pulse stops.
- R5: In the loop phase `loop_en` is 1 and `scan_blank` stays 1.
- R6: `scan_blank` falls at the field boundary that ends the Nth consecutive field in which `loop_stable` was 1 in every cycle. N is `settle_fields`, and a value of 0 counts as 1. The field that entered the loop phase is not counted.
- R7: A single cycle of `loop_stable` at 0 inside a field makes that field unstable and restarts the count from zero.
- R8: When `por` is 1 in a cycle, the next cycle is in the warm-up phase (`scan_blank` 1, `loop_en` 0), whatever the phase was. This holds even when that cycle is also a field boundary that would otherwise change the phase.
- R9: In normal operation `scan_blank` is 0, `loop_en` is 1 and `monitor_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por | input | 1 | Power-on reset event (supply dropped low), synchronous |
| vblank | input | 1 | Vertical blanking measurement window |
| warm_ok | input | 1 | Warm-up threshold comparator result |
| loop_stable | input | 1 | Cut-off loop has settled |
| settle_fields | input | CNT_W | Number of stable fields required before unblanking |
| scan_blank | output | 1 | Force RGB outputs to ultra-black during line scan |
| monitor_en | output | 1 | Enable white monitor pulse |
| loop_en | output | 1 | Enable cut-off and white-level control loops |

## Verification
Two events can land in the same cycle. One is a field boundary that would advance the phase, either by entering the loop phase or by releasing blanking. The other is a power-on reset event. The bench sets up a one-field settle count, so that the next boundary would release blanking, and raises `por` exactly in the boundary cycle. It expects warm-up outputs on the next edge and a monitor pulse in the following blanking window. The bench also sweeps every settle count from 0 to 4 against the position of an unstable field, and predicts the release field arithmetically.

// File: rtl/tube_startup_pkg.sv
package tube_startup_pkg;

   typedef enum logic [1:0] {
      PH_WARM   = 2'd0,
      PH_SETTLE = 2'd1,
      PH_RUN    = 2'd2
   } tss_phase_t;

endpackage

// File: rtl/tss_field_tick.sv
module tss_field_tick #(
   parameter bit END_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vblank,
   output logic tick
);
   logic vb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vb_q <= 1'b0;
      else        vb_q <= vblank;
   end

   generate
      if (END_EDGE) begin : g_end
         assign tick = vb_q & ~vblank;
      end else begin : g_start
         assign tick = ~vb_q & vblank;
      end
   endgenerate
endmodule

// File: rtl/tss_warm_latch.sv
module tss_warm_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic vblank,
   input  logic warm_ok,
   output logic seen
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                seen <= 1'b0;
      else if (clr)              seen <= 1'b0;
      else if (vblank && warm_ok) seen <= 1'b1;
   end

   AST_SEEN_FROM_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seen) |-> $past(vblank));  // R3
endmodule

// File: rtl/tss_stable_count.sv
module tss_stable_count #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic             tick,
   input  logic             loop_stable,
   input  logic [CNT_W-1:0] target,
   output logic             done
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt;
   logic             drop_seen;
   logic             field_ok;
   logic [EXT_W-1:0] next_ext;
   logic [EXT_W-1:0] tgt_eff;

   assign field_ok = ~drop_seen & loop_stable;
   assign next_ext = {1'b0, cnt} + EXT_W'(1);
   assign tgt_eff  = (target == '0) ? EXT_W'(1) : {1'b0, target};
   assign done     = en & tick & field_ok & (next_ext >= tgt_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            drop_seen <= 1'b0;
      else if (clr || tick)  drop_seen <= 1'b0;
      else if (!loop_stable) drop_seen <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr || !en)    cnt <= '0;
      else if (tick) begin
         if (!field_ok || done) cnt <= '0;
         else                   cnt <= next_ext[CNT_W-1:0];
      end
   end

   AST_UNSTABLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !loop_stable) |-> !done);  // R7
endmodule

// File: rtl/tube_startup_seq.sv
module tube_startup_seq
   import tube_startup_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter bit END_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por,
   input  logic             vblank,
   input  logic             warm_ok,
   input  logic             loop_stable,
   input  logic [CNT_W-1:0] settle_fields,
   output logic             scan_blank,
   output logic             monitor_en,
   output logic             loop_en
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("tube_startup_seq: CNT_W must lie in 1..16");
      end
   endgenerate

   tss_phase_t phase, phase_nx;
   logic       fld_tick;
   logic       warm_seen;
   logic       settle_done;

   tss_field_tick #(.END_EDGE(END_EDGE)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .vblank (vblank),
      .tick   (fld_tick)
   );

   tss_warm_latch u_warm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (por | fld_tick),
      .vblank  (vblank),
      .warm_ok (warm_ok),
      .seen    (warm_seen)
   );

   tss_stable_count #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (por),
      .en          (phase == PH_SETTLE),
      .tick        (fld_tick),
      .loop_stable (loop_stable),
      .target      (settle_fields),
      .done        (settle_done)
   );

   always_comb begin
      phase_nx = phase;
      if (por) begin
         phase_nx = PH_WARM;
      end else begin
         unique case (phase)
            PH_WARM:   if (fld_tick && warm_seen) phase_nx = PH_SETTLE;
            PH_SETTLE: if (settle_done)           phase_nx = PH_RUN;
            PH_RUN:    phase_nx = PH_RUN;
            default:   phase_nx = PH_WARM;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_WARM;
      else        phase <= phase_nx;
   end

   assign scan_blank = (phase != PH_RUN);
   assign loop_en    = (phase != PH_WARM);
   assign monitor_en = (phase == PH_WARM) & vblank;

   AST_MON_ONLY_WARM: assert property (@(posedge clk) disable iff (!rst_n)
      monitor_en |-> !loop_en);  // R2
   AST_RUN_UNBLANKED: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_blank |-> (loop_en && !monitor_en));  // R9
   AST_POR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      por |=> (scan_blank && !loop_en));  // R8
   AST_LOOP_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loop_en) |-> $past(fld_tick));  // R4
   AST_RELEASE_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_blank) |-> $past(fld_tick));  // R6
endmodule

// File: tb/tube_startup_seq_bench.sv
`timescale 1ns/1ps
module tube_startup_seq_bench;
   localparam int CNT_W = 3;
   localparam int VB    = 4;
   localparam int SC    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             por = 1'b0;
   logic             vblank = 1'b0;
   logic             warm_ok = 1'b0;
   logic             loop_stable = 1'b1;
   logic [CNT_W-1:0] settle_fields = '0;
   logic             scan_blank, monitor_en, loop_en;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #2 clk = ~clk;

   tube_startup_seq #(.CNT_W(CNT_W), .END_EDGE(1'b1)) u_tube_startup_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .por           (por),
      .vblank        (vblank),
      .warm_ok       (warm_ok),
      .loop_stable   (loop_stable),
      .settle_fields (settle_fields),
      .scan_blank    (scan_blank),
      .monitor_en    (monitor_en),
      .loop_en       (loop_en)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   // One field: blanking then scan. drop_idx marks a blanking cycle with loop_stable low.
   task automatic field(input bit wb, input bit ws, input int drop_idx,
                        input bit exp_mon, input bit por_tick);
      for (int i = 0; i < VB; i++) begin
         @(negedge clk);
         vblank = 1'b1; warm_ok = wb; loop_stable = (i != drop_idx); por = 1'b0;
         #1;
         if (i == 1) chk("R2 monitor in blanking", monitor_en, exp_mon);
      end
      for (int i = 0; i < SC; i++) begin
         @(negedge clk);
         vblank = 1'b0; warm_ok = ws; loop_stable = 1'b1;
         por = (por_tick && i == 0);
      end
      #1;
   endtask

   task automatic por_pulse();
      @(negedge clk); por = 1'b1;
      @(negedge clk); por = 1'b0;
      #1;
      chk("R8 por restart blank", scan_blank, 1'b1);
      chk("R8 por restart loop", loop_en, 1'b0);
   endtask

   task automatic run_case(input int n, input int drop);
      int  cnt;
      int  neff;
      bit  rel;
      settle_fields = CNT_W'(n);
      por_pulse();
      field(1'b0, 1'b0, -1, 1'b1, 1'b0);
      chk("R2 warm stays", loop_en, 1'b0);
      field(1'b0, 1'b1, -1, 1'b1, 1'b0);
      chk("R3 warm_ok in scan ignored", loop_en, 1'b0);
      field(1'b1, 1'b0, -1, 1'b1, 1'b0);
      chk("R4 loop enabled at boundary", loop_en, 1'b1);
      chk("R5 still blanked", scan_blank, 1'b1);
      neff = (n == 0) ? 1 : n;
      cnt  = 0;
      rel  = 1'b0;
      for (int k = 1; k <= 7; k++) begin
         field(1'b0, 1'b0, (k == drop) ? 2 : -1, 1'b0, 1'b0);
         if (!rel) begin
            if (k == drop) cnt = 0;
            else           cnt++;
            if (cnt >= neff) rel = 1'b1;
         end
         chk(rel ? "R9 released" : (k == drop ? "R7 drop restarts" : "R6 blank held"),
             scan_blank, !rel);
         chk("R5 R9 loop on", loop_en, 1'b1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 reset blank", scan_blank, 1'b1);
      chk("R1 reset loop", loop_en, 1'b0);
      chk("R1 reset monitor", monitor_en, 1'b0);

      for (int n = 0; n <= 4; n++)
         for (int d = 0; d <= 3; d++)
            run_case(n, d);

      // R8: por in the very cycle that would release blanking
      settle_fields = CNT_W'(1);
      por_pulse();
      field(1'b1, 1'b0, -1, 1'b1, 1'b0);
      chk("R4 enter loop phase", loop_en, 1'b1);
      field(1'b0, 1'b0, -1, 1'b0, 1'b1);
      chk("R8 por beats boundary blank", scan_blank, 1'b1);
      chk("R8 por beats boundary loop", loop_en, 1'b0);
      field(1'b0, 1'b0, -1, 1'b1, 1'b0);
      chk("R8 back in warm-up", loop_en, 1'b0);

      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!ended) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule